// File: doc/BRIEF.md
# Shared-Data-Line SPI Slave

This block is the slave end of a serial link between a controller and a radio core. It works from its own system clock. The master supplies a serial clock and an active-low select. A single data pin carries bits in both directions. The slave drives that pin only when a configuration bit, called turn, says the slave is the talker. At all other times it leaves the pin at high impedance so the master can drive it. Another configuration bit moves outgoing data onto a separate MISO pin. In that mode the shared pin becomes a plain master-to-slave input, and the link runs full duplex.

When the select is released, the block can present the radio's interrupt request on the shared pin. It gives the pin back to the data path as soon as the select is asserted. The serial clock, the select and the data input each pass through a two-flop synchronizer. Edges are then detected in the system clock domain. Frames are MSB first: data is sampled on the rising serial clock edge and launched on the falling edge.

Received bytes leave the block as a one-cycle strobe. Outgoing bytes are taken from an input bus, and a one-cycle load pulse marks each capture so that upstream logic can present the next byte. The register file and the command decoding sit outside this block.

Top module: `shdata_spi_slave`

## Requirements
- R1: While reset is active, and whenever the select has been high for three clocks with interrupt sharing off, rx_valid, tx_load, dio_oe and miso_oe are all 0. Pin ownership follows the select within three system clocks.
- R2: On each rising serial clock edge with the select low, the bit on dio_in is shifted in MSB first. After every eighth rising edge, rx_byte holds the byte and rx_valid is high for exactly one cycle. Bytes may follow one another under a single select.
- R3: rx_valid pulses only when receiving is enabled: three-wire mode with turn=0, or four-wire mode with any value of turn.
- R4: In three-wire mode with turn=1 and the select low, dio_oe=1 and dio_out shows the current transmit bit. The MSB is present before the first rising edge, and each later bit appears after a falling edge.
- R5: When transmitting is enabled (turn=1, or four-wire mode), tx_byte is captured and tx_load is high for exactly one cycle. This happens when the select goes low and after each eighth rising edge, so N full bytes under one select give N+1 loads. When transmitting is not enabled, tx_load stays 0.
- R6: In three-wire mode with turn=0 and the select low, dio_oe=0.
- R7: Raising the select clears the bit position. A partial byte produces no rx_valid, and the next transfer starts a fresh byte, both on the receive side and on the transmit side.
- R8: With the select high and cfg_irq_share=1, dio_oe=1 and dio_out equals irq_in. With cfg_irq_share=0, dio_oe=0.
- R9: While the select is low, irq_in never reaches the shared pin. With sharing on and turn=0 the pin is released, and it is given back to the interrupt when the select rises.
- R10: In four-wire mode with the select low, dio_oe=0, miso_oe=1 and miso_out carries the transmit bits, while receive on dio_in continues. miso_oe=0 while the select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial clock from the master |
| ss_n_in | input | 1 | Active-low slave select |
| dio_in | input | 1 | Input side of the shared data pin |
| dio_out | output | 1 | Output value for the shared data pin |
| dio_oe | output | 1 | Output enable of the shared data pin |
| miso_out | output | 1 | Separate MISO output (four-wire mode) |
| miso_oe | output | 1 | Output enable of the MISO pin |
| irq_in | input | 1 | Interrupt request from the radio core |
| cfg_turn | input | 1 | Direction: 1 = slave transmits on the shared pin |
| cfg_four_wire | input | 1 | 1 = outgoing data on the MISO pin, full duplex |
| cfg_irq_share | input | 1 | 1 = interrupt on the shared pin while deselected |
| tx_byte | input | DATA_W | Next byte to transmit |
| tx_load | output | 1 | One-cycle pulse: tx_byte captured |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_byte updated |

## Verification
A bit counter that drifts shows up as a wrong rx_byte, or a missing rx_valid strobe, on the very next byte. Transmit bits that are shifted at the wrong moment corrupt the serial byte the master reads back within one frame. A pin multiplexer that picks the wrong owner is visible within three system clocks of a change on the select: the output enables show it, and so does the interrupt echo on dio_out. The sweeps push every byte value through both directions, so a stuck or swapped data bit cannot hide.

// File: rtl/shspi_pkg.sv
package shspi_pkg;

    localparam int SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic turn;
        logic four_wire;
        logic irq_share;
    } shspi_cfg_t;

    typedef struct packed {
        logic dat;
        logic oe;
    } shspi_pin_t;

    function automatic logic rx_enabled(shspi_cfg_t c);
        return c.four_wire || !c.turn;
    endfunction

    function automatic logic tx_enabled(shspi_cfg_t c);
        return c.four_wire || c.turn;
    endfunction

endpackage

// File: rtl/shspi_sync.sv
module shspi_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/shspi_engine.sv
module shspi_engine
    import shspi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ss_act,
    input  logic              sck_s,
    input  logic              din_s,
    input  shspi_cfg_t        cfg,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              tx_load,
    output logic              tx_bit
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DATA_W - 1);

    logic              sck_d, ss_d;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx_sh, tx_sh;
    logic              shift_due;
    logic              rise, fall, start, last;
    logic [DATA_W-1:0] rx_next;

    assign rise    = sck_s & ~sck_d;
    assign fall    = ~sck_s & sck_d;
    assign start   = ss_act & ~ss_d;
    assign last    = (cnt == LAST_POS);
    assign rx_next = {rx_sh[DATA_W-2:0], din_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d     <= 1'b0;
            ss_d      <= 1'b0;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            tx_load   <= 1'b0;
            shift_due <= 1'b0;
        end else begin
            sck_d    <= sck_s;
            ss_d     <= ss_act;
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
            if (!ss_act) begin
                cnt       <= '0;
                shift_due <= 1'b0;
            end else if (start) begin
                cnt       <= '0;
                shift_due <= 1'b0;
                tx_sh     <= tx_byte;
                tx_load   <= tx_enabled(cfg);
            end else if (rise) begin
                rx_sh <= rx_next;
                if (last) begin
                    cnt       <= '0;
                    rx_byte   <= rx_next;
                    rx_valid  <= rx_enabled(cfg);
                    tx_sh     <= tx_byte;
                    tx_load   <= tx_enabled(cfg);
                    shift_due <= 1'b0;
                end else begin
                    cnt       <= cnt + 1'b1;
                    shift_due <= 1'b1;
                end
            end else if (fall && shift_due) begin
                tx_sh     <= {tx_sh[DATA_W-2:0], 1'b0};
                shift_due <= 1'b0;
            end
        end
    end

    assign tx_bit = tx_sh[DATA_W-1];
endmodule

// File: rtl/shspi_pinmux.sv
module shspi_pinmux
    import shspi_pkg::*;
(
    input  logic       ss_act,
    input  shspi_cfg_t cfg,
    input  logic       tx_bit,
    input  logic       irq_in,
    output shspi_pin_t dio,
    output shspi_pin_t miso
);
    always_comb begin
        dio  = '0;
        miso = '0;
        if (ss_act) begin
            if (cfg.four_wire) begin
                miso.oe  = 1'b1;
                miso.dat = tx_bit;
            end else if (cfg.turn) begin
                dio.oe  = 1'b1;
                dio.dat = tx_bit;
            end
        end else if (cfg.irq_share) begin
            dio.oe  = 1'b1;
            dio.dat = irq_in;
        end
    end
endmodule

// File: rtl/shdata_spi_slave.sv
module shdata_spi_slave
    import shspi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_in,
    input  logic              ss_n_in,
    input  logic              dio_in,
    output logic              dio_out,
    output logic              dio_oe,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              irq_in,
    input  logic              cfg_turn,
    input  logic              cfg_four_wire,
    input  logic              cfg_irq_share,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_load,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw, synced;
    logic             ss_act, tx_bit;
    shspi_cfg_t       cfg;
    shspi_pin_t       dio, miso;

    assign raw = {ss_n_in, sck_in, dio_in};
    assign cfg = '{turn: cfg_turn, four_wire: cfg_four_wire, irq_share: cfg_irq_share};

    shspi_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign ss_act = ~synced[2];

    shspi_engine #(.DATA_W(DATA_W)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ss_act   (ss_act),
        .sck_s    (synced[1]),
        .din_s    (synced[0]),
        .cfg      (cfg),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .tx_load  (tx_load),
        .tx_bit   (tx_bit)
    );

    shspi_pinmux u_pinmux (
        .ss_act (ss_act),
        .cfg    (cfg),
        .tx_bit (tx_bit),
        .irq_in (irq_in),
        .dio    (dio),
        .miso   (miso)
    );

    assign dio_out  = dio.dat;
    assign dio_oe   = dio.oe;
    assign miso_out = miso.dat;
    assign miso_oe  = miso.oe;
endmodule

// File: rtl/shdata_spi_slave_chk.sv
module shdata_spi_slave_chk (
    input logic clk,
    input logic rst,
    input logic ss_n_in,
    input logic cfg_turn,
    input logic cfg_four_wire,
    input logic cfg_irq_share,
    input logic irq_in,
    input logic dio_out,
    input logic dio_oe,
    input logic miso_oe,
    input logic rx_valid,
    input logic tx_load
);
    a_r2_rx_strobe_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r5_load_single: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

    a_r3_rx_dir: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(cfg_four_wire) || !$past(cfg_turn)));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (ss_n_in && $past(ss_n_in) && $past(ss_n_in, 2) && !cfg_irq_share)
        |-> (!dio_oe && !miso_oe));

    a_r8_irq_pin: assert property (@(posedge clk) disable iff (rst)
        (ss_n_in && $past(ss_n_in) && $past(ss_n_in, 2) && cfg_irq_share)
        |-> (dio_oe && dio_out == irq_in));

    a_r6_hiz: assert property (@(posedge clk) disable iff (rst)
        (!ss_n_in && !$past(ss_n_in) && !$past(ss_n_in, 2) && !cfg_four_wire && !cfg_turn)
        |-> !dio_oe);

    a_r9_no_irq_busy: assert property (@(posedge clk) disable iff (rst)
        (!ss_n_in && !$past(ss_n_in) && !$past(ss_n_in, 2) && cfg_irq_share && !cfg_turn)
        |-> !dio_oe);

    a_r10_four_wire: assert property (@(posedge clk) disable iff (rst)
        (!ss_n_in && !$past(ss_n_in) && !$past(ss_n_in, 2) && cfg_four_wire)
        |-> (!dio_oe && miso_oe));
endmodule

bind shdata_spi_slave shdata_spi_slave_chk u_chk (.*);

// File: tb/shdata_spi_slave_test.sv
module shdata_spi_slave_test;
    localparam int W = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic sck = 1'b0, ss_n = 1'b1, dio_drv = 1'b0, irq = 1'b0;
    logic turn = 1'b0, four = 1'b0, share = 1'b0;
    logic [W-1:0] tx_byte, rx_byte;
    logic dio_out, dio_oe, miso_out, miso_oe, rx_valid, tx_load;
    int nchk = 0, nerr = 0, ngot = 0, nload = 0, cyc = 0;
    logic [W-1:0] got [1024];

    always #10 clk = ~clk;

    function automatic logic [W-1:0] txpat(int k);
        return W'(k * 37 + 5);
    endfunction

    assign tx_byte = txpat(nload);

    shdata_spi_slave #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .sck_in(sck), .ss_n_in(ss_n), .dio_in(dio_drv),
        .dio_out(dio_out), .dio_oe(dio_oe), .miso_out(miso_out), .miso_oe(miso_oe),
        .irq_in(irq), .cfg_turn(turn), .cfg_four_wire(four), .cfg_irq_share(share),
        .tx_byte(tx_byte), .tx_load(tx_load), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got[ngot % 1024] <= rx_byte;
            ngot <= ngot + 1;
        end
        if (tx_load) nload <= nload + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel(input bit low);
        ss_n = !low;
        idle(8);
    endtask

    task automatic xfer(input logic [W-1:0] mo, input int nbits, input bit from_miso,
                        output logic [W-1:0] mi, output bit oe_any, output bit oe_all);
        mi = '0; oe_any = 1'b0; oe_all = 1'b1;
        for (int i = W - 1; i >= W - nbits; i--) begin
            dio_drv = mo[i];
            idle(4);
            mi[i]  = from_miso ? miso_out : dio_out;
            oe_any = oe_any | dio_oe;
            oe_all = oe_all & dio_oe;
            sck = 1'b1;
            idle(4);
            sck = 1'b0;
        end
    endtask

    initial begin
        logic [W-1:0] mi;
        bit a, al;
        int g0, l0;
        idle(4);
        chk({rx_valid, tx_load, dio_oe, miso_oe} == 4'b0, "R1 reset",
            int'({rx_valid, tx_load, dio_oe, miso_oe}), 0);
        rst = 1'b0;
        idle(6);
        chk({rx_valid, tx_load, dio_oe, miso_oe} == 4'b0, "R1 idle",
            int'({rx_valid, tx_load, dio_oe, miso_oe}), 0);

        // R2/R3/R6: receive sweep of all byte values, turn=0
        turn = 1'b0; g0 = ngot; l0 = nload;
        sel(1);
        for (int b = 0; b < 256; b++) begin
            xfer(W'(b), 8, 1'b0, mi, a, al);
            chk(!a, "R6 dio_oe while receiving", int'(a), 0);
        end
        idle(8);
        sel(0);
        chk(ngot - g0 == 256, "R2 byte count", ngot - g0, 256);
        for (int b = 0; b < 256; b++)
            chk(got[(g0 + b) % 1024] == W'(b), "R2 rx_byte", int'(got[(g0 + b) % 1024]), b);
        chk(nload == l0, "R5 no load when receiving", nload - l0, 0);

        // R4/R5/R3: transmit sweep, turn=1
        turn = 1'b1; idle(2); g0 = ngot; l0 = nload;
        sel(1);
        for (int j = 0; j < 256; j++) begin
            xfer(~W'(j), 8, 1'b0, mi, a, al);
            chk(mi == txpat(l0 + j), "R4 tx byte", int'(mi), int'(txpat(l0 + j)));
            chk(al, "R4 dio_oe while transmitting", int'(al), 1);
        end
        sel(0);
        chk(nload - l0 == 257, "R5 load count", nload - l0, 257);
        chk(ngot == g0, "R3 no rx_valid when transmitting", ngot - g0, 0);

        // R7: partial byte discarded, receive side
        turn = 1'b0; idle(2); g0 = ngot;
        sel(1);
        xfer(8'hFF, 5, 1'b0, mi, a, al);
        sel(0);
        chk(ngot == g0, "R7 partial no strobe", ngot - g0, 0);
        sel(1);
        xfer(8'h5A, 8, 1'b0, mi, a, al);
        idle(8);
        sel(0);
        chk(ngot == g0 + 1, "R7 realigned count", ngot - g0, 1);
        chk(got[g0 % 1024] == 8'h5A, "R7 realigned byte", int'(got[g0 % 1024]), 'h5A);

        // R7: partial byte discarded, transmit side
        turn = 1'b1; idle(2); l0 = nload;
        sel(1);
        xfer(8'h00, 3, 1'b0, mi, a, al);
        sel(0);
        sel(1);
        xfer(8'h00, 8, 1'b0, mi, a, al);
        sel(0);
        chk(mi == txpat(l0 + 1), "R7 tx restart", int'(mi), int'(txpat(l0 + 1)));

        // R8: interrupt on the shared pin while deselected
        turn = 1'b0; share = 1'b1; irq = 1'b0; idle(2);
        chk(dio_oe && dio_out == 1'b0, "R8 irq low", int'({dio_oe, dio_out}), 2);
        irq = 1'b1; idle(1);
        chk(dio_oe && dio_out == 1'b1, "R8 irq high", int'({dio_oe, dio_out}), 3);
        share = 1'b0; idle(1);
        chk(!dio_oe, "R8 sharing off", int'(dio_oe), 0);

        // R9: interrupt withheld while selected
        share = 1'b1; idle(1);
        sel(1);
        chk(!dio_oe, "R9 pin released", int'(dio_oe), 0);
        irq = 1'b0; idle(2);
        chk(!dio_oe, "R9 irq toggle hidden", int'(dio_oe), 0);
        sel(0);
        chk(dio_oe && dio_out == irq, "R9 irq restored", int'({dio_oe, dio_out}), 2);
        share = 1'b0; idle(2);

        // R10: four-wire full duplex
        four = 1'b1; turn = 1'b1; idle(2); g0 = ngot; l0 = nload;
        sel(1);
        chk(miso_oe, "R10 miso enabled", int'(miso_oe), 1);
        for (int j = 0; j < 16; j++) begin
            xfer(W'(j * 11 + 3), 8, 1'b1, mi, a, al);
            chk(!a, "R10 dio not driven", int'(a), 0);
            chk(mi == txpat(l0 + j), "R10 miso byte", int'(mi), int'(txpat(l0 + j)));
        end
        idle(8);
        sel(0);
        chk(!miso_oe, "R10 miso released", int'(miso_oe), 0);
        chk(ngot - g0 == 16, "R10 rx count", ngot - g0, 16);
        for (int j = 0; j < 16; j++)
            chk(got[(g0 + j) % 1024] == W'(j * 11 + 3), "R10 rx byte",
                int'(got[(g0 + j) % 1024]), (j * 11 + 3) % 256);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc == 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule